// File: doc/BRIEF.md
# Memory-Mapped 16x16 Unsigned Multiplier

This peripheral lets a small 16-bit processor hand off an unsigned 16 by 16 multiplication to hardware. It sits on a simple synchronous peripheral bus with these signals:

- address
- write data
- write strobe
- select
- read data

Software uses it in four steps:

1. Store the two operands.
2. Write the control word with bit 0 cleared.
3. Write the control word with bit 0 set.
4. Read the 32-bit product back as two 16-bit halves.

The multiply fires only when the stored control bit goes from 0 to 1. The product comes from one combinational multiplier and is captured into two result registers one clock later.

Five word registers sit at even offsets from a parameterised base address, in this order:

| Offset | Register |
|--------|----------|
| 0x0 | Operand X |
| 0x2 | Operand Y |
| 0x4 | Control |
| 0x6 | Low product |
| 0x8 | High product |

Only the two product registers can be read. In every other case the read-data output is zero, so the output can be OR-merged with the read data of other slaves.

Top module: `mmio_mult16`

## Requirements
- R1: After the asynchronous active-low reset is released, both product registers read back as 0.
- R2: A register is written only when select and write strobe are both 1 and the address decodes to a writable register. The base address must match in address bits [15:4], and bits [3:1] choose the register as 0=X, 1=Y, 2=control. Other writes change nothing.
- R3: Reading offset 0x6 returns product bits [15:0], and reading offset 0x8 returns product bits [31:16], of the unsigned product X*Y.
- R4: Only write-data bit 0 is stored as the control bit. The remaining 15 bits are ignored.
- R5: A multiply starts only on a 0-to-1 transition of the stored control bit. Writing 1 while it is already 1 starts nothing.
- R6: The product registers take their new value on the clock edge that follows the edge storing the control 1. Before that edge they still read the old value.
- R7: Read data is 0 in each of these cases: select is 0, write strobe is 1, the base does not match, or the offset is not a product register.
- R8: Changing operands without a new rising control edge leaves the product registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_en | input | 1 | Peripheral select |
| bus_rdata | output | 16 | Read data, zero unless a product register is read |

## Verification
The bench drives these operand corners: 0, 1 and 0xFFFF, including 0xFFFF*0xFFFF. A wrong split between the two halves, or a truncated product, shows up there as a wrong high word.

It also targets the start rule:
- It writes 1 twice in a row.
- It writes a control word whose low bit is 0 but whose upper bits are all set.
- It writes a control word with bits 15 and 0 set.

A design that triggered on the level of the bit, or on any non-zero word, would then recompute with fresh operands.

Writes with select low, with an address outside the base, or to an unused offset must leave the operands untouched. Reads of operand, control and unused addresses must return zero. One test samples the low word one cycle after the control write, to catch a result that appears a cycle early or late.

// File: rtl/mmul_pkg.sv
package mmul_pkg;
  localparam int NUM_REGS = 5;
  localparam int IDX_W    = 3;
  localparam int OFS_W    = 4;

  typedef enum logic [IDX_W-1:0] {
    IDX_OPX  = 3'd0,
    IDX_OPY  = 3'd1,
    IDX_CTL  = 3'd2,
    IDX_PLO  = 3'd3,
    IDX_PHI  = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/mmul_addr_dec.sv
module mmul_addr_dec
  import mmul_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0140
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                en_i,
  input  logic                we_i,
  output logic [NUM_REGS-1:0] wr_sel_o,
  output logic [NUM_REGS-1:0] rd_sel_o
);
  logic             base_hit;
  logic [IDX_W-1:0] idx;

  assign base_hit = en_i && (addr_i[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
  assign idx      = addr_i[OFS_W-1:1];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign wr_sel_o[i] = base_hit &&  we_i && (idx == IDX_W'(i));
    assign rd_sel_o[i] = base_hit && !we_i && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/mmul_edge_det.sv
module mmul_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/mmul_core.sv
module mmul_core #(
  parameter int DATA_W = 16,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [PROD_W-1:0] prod_o
);
  assign prod_o = PROD_W'(x_i) * PROD_W'(y_i);
endmodule

// File: rtl/mmio_mult16.sv
module mmio_mult16
  import mmul_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_en,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int PROD_W = 2 * DATA_W;

  logic [NUM_REGS-1:0] wr_sel, rd_sel;
  logic [DATA_W-1:0]   opx_q, opx_d, opy_q, opy_d;
  logic [DATA_W-1:0]   plo_q, plo_d, phi_q, phi_d;
  logic                ctl_q, ctl_d;
  logic                start;
  logic                ctl_wr;
  logic [PROD_W-1:0]   product;

  mmul_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) dec_i (
    .addr_i   (bus_addr),
    .en_i     (bus_en),
    .we_i     (bus_we),
    .wr_sel_o (wr_sel),
    .rd_sel_o (rd_sel)
  );

  mmul_edge_det edge_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (ctl_q),
    .rise_o (start)
  );

  mmul_core #(.DATA_W(DATA_W)) core_i (
    .x_i    (opx_q),
    .y_i    (opy_q),
    .prod_o (product)
  );

  assign ctl_wr = wr_sel[IDX_CTL];

  // next-state logic
  always_comb begin
    opx_d = opx_q;
    opy_d = opy_q;
    ctl_d = ctl_q;
    plo_d = plo_q;
    phi_d = phi_q;
    if (wr_sel[IDX_OPX]) opx_d = bus_wdata;
    if (wr_sel[IDX_OPY]) opy_d = bus_wdata;
    if (ctl_wr)          ctl_d = bus_wdata[0];
    if (start) begin
      plo_d = product[DATA_W-1:0];
      phi_d = product[PROD_W-1:DATA_W];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opx_q <= '0;
      opy_q <= '0;
      ctl_q <= 1'b0;
      plo_q <= '0;
      phi_q <= '0;
    end else begin
      opx_q <= opx_d;
      opy_q <= opy_d;
      ctl_q <= ctl_d;
      plo_q <= plo_d;
      phi_q <= phi_d;
    end
  end

  // read-back: only product words are visible, zero otherwise
  always_comb begin
    bus_rdata = '0;
    if (rd_sel[IDX_PLO]) bus_rdata = plo_q;
    if (rd_sel[IDX_PHI]) bus_rdata = phi_q;
  end
endmodule

// File: rtl/mmul_chk.sv
module mmul_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic              wbit0,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              ctl_wr,
  input logic              ctl_q,
  input logic              start,
  input logic [DATA_W-1:0] opx,
  input logic [DATA_W-1:0] opy,
  input logic [DATA_W-1:0] plo,
  input logic [DATA_W-1:0] phi
);
  localparam int PW = 2 * DATA_W;

  // R7
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && !bus_we) |-> bus_rdata == '0);

  // R4
  ctl_bit_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ctl_q == $past(wbit0));

  // R5
  single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  // R6
  product_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> {phi, plo} == PW'($past(opx)) * PW'($past(opy)));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable({phi, plo}));
endmodule

bind mmio_mult16 mmul_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .wbit0     (bus_wdata[0]),
  .bus_rdata (bus_rdata),
  .ctl_wr    (ctl_wr),
  .ctl_q     (ctl_q),
  .start     (start),
  .opx       (opx_q),
  .opy       (opy_q),
  .plo       (plo_q),
  .phi       (phi_q)
);

// File: tb/mmio_mult16_tb.sv
module mmio_mult16_tb_top;
  localparam logic [15:0] BASE = 16'h0140;
  localparam logic [15:0] A_X = BASE + 16'h0, A_Y = BASE + 16'h2, A_C = BASE + 16'h4;
  localparam logic [15:0] A_LO = BASE + 16'h6, A_HI = BASE + 16'h8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic        bus_we = 1'b0, bus_en = 1'b0;
  logic [15:0] bus_rdata;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  mmio_mult16 dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_en(bus_en), .bus_rdata(bus_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(logic [15:0] a, logic [15:0] d, logic en, logic we);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_en = en; bus_we = we;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    bus_cycle(a, d, 1'b1, 1'b1);
  endtask

  task automatic rd(logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_en = 1'b1; bus_we = 1'b0;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic read_prod(output logic [31:0] p);
    logic [15:0] lo, hi;
    rd(A_LO, lo);
    rd(A_HI, hi);
    p = {hi, lo};
  endtask

  task automatic run_mul(logic [15:0] x, logic [15:0] y, string req);
    logic [31:0] p;
    wr(A_X, x); wr(A_Y, y); wr(A_C, 16'h0); wr(A_C, 16'h1);
    read_prod(p);
    check(req, p, 32'(x) * 32'(y));
  endtask

  task automatic test_reset;
    logic [15:0] d;
    rd(A_LO, d); check("R1 low after reset", 32'(d), 32'h0);
    rd(A_HI, d); check("R1 high after reset", 32'(d), 32'h0);
  endtask

  task automatic test_corners;
    run_mul(16'h0000, 16'h0000, "R3 0*0");
    run_mul(16'h0000, 16'hFFFF, "R3 0*FFFF");
    run_mul(16'h0001, 16'hFFFF, "R3 1*FFFF");
    run_mul(16'hFFFF, 16'h0001, "R3 FFFF*1");
    run_mul(16'hFFFF, 16'hFFFF, "R3 FFFF*FFFF");
  endtask

  task automatic test_random;
    for (int i = 0; i < 8; i++) run_mul(16'($urandom), 16'($urandom), "R3 random");
  endtask

  task automatic test_double_one;
    logic [31:0] p;
    run_mul(16'd3, 16'd5, "R3 3*5");
    wr(A_X, 16'd7);
    wr(A_C, 16'h1);
    read_prod(p);
    check("R5 second 1 no start", p, 32'd15);
  endtask

  task automatic test_ctl_mask;
    logic [31:0] p;
    wr(A_C, 16'h0);
    wr(A_X, 16'd9); wr(A_Y, 16'd9);
    read_prod(p);
    check("R8 new operands hold result", p, 32'd15);
    wr(A_C, 16'hFFFE);
    read_prod(p);
    check("R4 upper ctl bits ignored", p, 32'd15);
    wr(A_C, 16'h8001);
    read_prod(p);
    check("R4 bit0 starts", p, 32'd81);
  endtask

  task automatic test_gating;
    logic [31:0] p;
    bus_cycle(A_X, 16'd100, 1'b0, 1'b1);          // not selected
    bus_cycle(16'h0240, 16'd100, 1'b1, 1'b1);     // other base
    bus_cycle(BASE + 16'hA, 16'd100, 1'b1, 1'b1); // unused offset
    bus_cycle(A_Y, 16'd100, 1'b1, 1'b0);          // read, not write
    wr(A_C, 16'h0); wr(A_C, 16'h1);
    read_prod(p);
    check("R2 ignored writes keep operands", p, 32'd81);
  endtask

  task automatic test_read_zero;
    logic [15:0] d;
    rd(A_X, d);  check("R7 operand read zero", 32'(d), 32'h0);
    rd(A_C, d);  check("R7 control read zero", 32'(d), 32'h0);
    rd(16'h0246, d); check("R7 other base zero", 32'(d), 32'h0);
    @(negedge clk);
    bus_addr = A_LO; bus_en = 1'b0; bus_we = 1'b0;
    #1 check("R7 unselected zero", 32'(bus_rdata), 32'h0);
    bus_en = 1'b1; bus_we = 1'b1; bus_wdata = 16'h1234;
    #1 check("R7 write strobe zero", 32'(bus_rdata), 32'h0);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    rd(A_LO, d); check("R2 result not writable", 32'(d), 32'd81);
  endtask

  task automatic test_latency;
    wr(A_X, 16'd4); wr(A_Y, 16'd6); wr(A_C, 16'h0); wr(A_C, 16'h1);
    bus_addr = A_LO; bus_en = 1'b1; bus_we = 1'b0;
    #1 check("R6 old value before capture", 32'(bus_rdata), 32'd81);
    @(negedge clk);
    #1 check("R6 new value after capture", 32'(bus_rdata), 32'd24);
    bus_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_corners();
    test_random();
    test_double_one();
    test_ctl_mask();
    test_gating();
    test_read_zero();
    test_latency();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule